// File: doc/BRIEF.md
# Multichannel CIC Interpolator

This block raises the sample rate of several complex (I/Q) channels by a fixed factor using a fifth-order cascaded integrator-comb structure. Low-rate samples enter one at a time on a shared input, each tagged with its channel number. A single comb section serves all channels. It keeps a separate set of difference-stage histories for each channel, selected by the tag. Each comb result waits in a per-channel holding register. Once per frame, the held value enters that channel's own integrator chain, and zeros are fed in the cycles between. The integrators run on every clock and give one high-rate output per channel per cycle.

The clock runs at the high rate. A frame is RATE clock cycles long and starts at phase 0 of a free-running phase counter. Within one frame each channel may deliver at most one sample, in any cycle of that frame. One synchronous clear input empties every internal register at once: comb histories, holding registers, integrators and the phase counter. Accumulators are wide enough that the filter result is exact. The output is a fixed bit slice of the last integrator, which divides out the filter's gain.

Top module: `cic_mc_interp`

## Requirements
- R1: After reset is released, every output is zero and the phase counter stands at 0, so the first cycle after reset is phase 0 of a frame.
- R2: Each channel's integrator chain takes its held comb value only in the phase-0 cycle and takes zero in the other RATE-1 cycles. A sample held before phase 0 appears at the output one clock after that phase-0 cycle.
- R3: The comb computes a fifth-order first difference of each channel's own low-rate sequence. Its delay histories are indexed by the channel tag (0..NCH-1), and an idle cycle leaves them unchanged.
- R4: If a sample arrives in the phase-0 cycle, the integrators take the value held before it, and the new comb result is kept for the next frame.
- R5: A sample for one channel never changes the output of any other channel.
- R6: A constant input x settles to the output value floor(x·RATE^(ORDER-1) / 2^SHIFT). For the defaults, 32767 gives 20735 and -32768 gives -20736.
- R7: When clear is high, every internal register is zero after that clock edge. Clear takes priority over an input sample in the same cycle, and that sample leaves no trace.
- R8: Accumulators are W_IN + ceil(ORDER·log2 RATE) bits wide (29 by default). The output is the accumulator bits [SHIFT+W_IN-1:SHIFT], with SHIFT = ceil(log2 RATE^(ORDER-1)) = 11 by default. Full-scale alternating inputs give the exact result.
- R9: A channel that delivers no sample in a frame feeds a zero comb value to its integrators at the next phase 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | High-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Synchronous clear of all internal registers |
| in_valid | input | 1 | A low-rate sample is present this cycle |
| in_ch | input | CHW | Channel tag of the sample |
| in_i | input | W_IN | In-phase sample, signed |
| in_q | input | W_IN | Quadrature sample, signed |
| out_i | output | NCH·W_IN | In-phase outputs, channel k at bits [k·W_IN +: W_IN] |
| out_q | output | NCH·W_IN | Quadrature outputs, same packing |

## Verification
Two events can fall on the same clock edge. In the phase-0 cycle the holding register hands its value to the integrators and can receive a new comb result. Separately, a clear can arrive together with an input sample. The bench provokes the first case by sweeping the slot offset of the channel arrivals so that channel 0 lands on phase 0. It provokes the second by asserting clear while a sample is valid. An arithmetic model in the bench checks every output of every cycle: a consumed value must not be lost or reused, and a cleared sample must never show up.

// File: rtl/cic_mc_pkg.sv
package cic_mc_pkg;

    // integer power b**e for elaboration-time sizing
    function automatic int ipow(input int b, input int e);
        int p;
        p = 1;
        for (int i = 0; i < e; i++) p = p * b;
        return p;
    endfunction

    // smallest g such that 2**g >= v
    function automatic int bits_for(input int v);
        int g;
        g = 0;
        for (int i = 0; i < 31; i++) begin
            if ((1 << g) < v) g = g + 1;
        end
        return g;
    endfunction

endpackage

// File: rtl/cic_comb_shared.sv
module cic_comb_shared #(
    parameter int NCH   = 2,
    parameter int ORDER = 5,
    parameter int W_ACC = 29,
    parameter int CHW   = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             valid,
    input  logic [CHW-1:0]   ch,
    input  logic [W_ACC-1:0] x_i,
    input  logic [W_ACC-1:0] x_q,
    output logic [W_ACC-1:0] y_i,
    output logic [W_ACC-1:0] y_q
);

    typedef struct packed {
        logic [ORDER-1:0][NCH-1:0][W_ACC-1:0] hist_i;
        logic [ORDER-1:0][NCH-1:0][W_ACC-1:0] hist_q;
    } comb_t;

    comb_t           q, d;
    logic [W_ACC-1:0] acc_i, acc_q, prev_i, prev_q;
    logic [CHW-1:0]  idx;
    logic            ch_ok;

    always_comb begin
        ch_ok = (int'(ch) < NCH);
        idx   = ch_ok ? ch : '0;
        d     = q;
        acc_i = x_i;
        acc_q = x_q;
        for (int k = 0; k < ORDER; k++) begin
            prev_i = acc_i;
            prev_q = acc_q;
            acc_i  = acc_i - q.hist_i[k][idx];
            acc_q  = acc_q - q.hist_q[k][idx];
            if (valid && ch_ok) begin
                d.hist_i[k][idx] = prev_i;
                d.hist_q[k][idx] = prev_q;
            end
        end
        if (flush) d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign y_i = acc_i;
    assign y_q = acc_q;

    // R3: an idle cycle leaves the channel histories untouched
    assert_comb_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid && !flush) |=> $stable(q));

    // R7: clear empties every history
    assert_comb_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (q == '0));

endmodule

// File: rtl/cic_integ_chain.sv
module cic_integ_chain #(
    parameter int ORDER = 5,
    parameter int W_ACC = 29,
    parameter int W_IN  = 16,
    parameter int SHIFT = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [W_ACC-1:0] x_i,
    input  logic [W_ACC-1:0] x_q,
    output logic [W_IN-1:0]  y_i,
    output logic [W_IN-1:0]  y_q
);

    typedef struct packed {
        logic [ORDER-1:0][W_ACC-1:0] sum_i;
        logic [ORDER-1:0][W_ACC-1:0] sum_q;
    } integ_t;

    integ_t           q, d;
    logic [W_ACC-1:0] run_i, run_q;

    always_comb begin
        d     = q;
        run_i = x_i;
        run_q = x_q;
        for (int k = 0; k < ORDER; k++) begin
            run_i        = q.sum_i[k] + run_i;
            run_q        = q.sum_q[k] + run_q;
            d.sum_i[k]   = run_i;
            d.sum_q[k]   = run_q;
        end
        if (flush) d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign y_i = q.sum_i[ORDER-1][SHIFT +: W_IN];
    assign y_q = q.sum_q[ORDER-1][SHIFT +: W_IN];

    // R7: clear empties the whole chain
    assert_integ_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (q == '0));

    // R2: a zero-stuffed cycle leaves the first stage holding its value
    assert_zero_stuff_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && x_i == '0 && x_q == '0) |=> $stable(q.sum_i[0]) && $stable(q.sum_q[0]));

endmodule

// File: rtl/cic_mc_interp.sv
module cic_mc_interp
    import cic_mc_pkg::*;
#(
    parameter int NCH   = 2,
    parameter int RATE  = 6,
    parameter int ORDER = 5,
    parameter int W_IN  = 16,
    localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flush,
    input  logic                in_valid,
    input  logic [CHW-1:0]      in_ch,
    input  logic [W_IN-1:0]     in_i,
    input  logic [W_IN-1:0]     in_q,
    output logic [NCH*W_IN-1:0] out_i,
    output logic [NCH*W_IN-1:0] out_q
);

    localparam int GROWTH = bits_for(ipow(RATE, ORDER));
    localparam int W_ACC  = W_IN + GROWTH;
    localparam int SHIFT  = bits_for(ipow(RATE, ORDER - 1));
    localparam int PHW    = (bits_for(RATE) > 0) ? bits_for(RATE) : 1;

    typedef struct packed {
        logic [PHW-1:0]              phase;
        logic [NCH-1:0][W_ACC-1:0]   hold_i;
        logic [NCH-1:0][W_ACC-1:0]   hold_q;
    } ctl_t;

    ctl_t             q, d;
    logic [W_ACC-1:0] ext_i, ext_q, comb_i, comb_q;
    logic             feed;

    assign ext_i = {{GROWTH{in_i[W_IN-1]}}, in_i};
    assign ext_q = {{GROWTH{in_q[W_IN-1]}}, in_q};
    assign feed  = (q.phase == '0);

    cic_comb_shared #(
        .NCH(NCH), .ORDER(ORDER), .W_ACC(W_ACC), .CHW(CHW)
    ) u_comb (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .valid(in_valid), .ch(in_ch),
        .x_i(ext_i), .x_q(ext_q),
        .y_i(comb_i), .y_q(comb_q)
    );

    always_comb begin
        d = q;
        if (feed) begin
            d.hold_i = '0;
            d.hold_q = '0;
        end
        if (in_valid && (int'(in_ch) < NCH)) begin
            d.hold_i[in_ch] = comb_i;
            d.hold_q[in_ch] = comb_q;
        end
        d.phase = (int'(q.phase) == RATE - 1) ? '0 : q.phase + 1'b1;
        if (flush) d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    for (genvar k = 0; k < NCH; k++) begin : g_chan
        logic [W_ACC-1:0] stuff_i, stuff_q;
        assign stuff_i = feed ? q.hold_i[k] : '0;
        assign stuff_q = feed ? q.hold_q[k] : '0;
        cic_integ_chain #(
            .ORDER(ORDER), .W_ACC(W_ACC), .W_IN(W_IN), .SHIFT(SHIFT)
        ) u_integ (
            .clk(clk), .rst_n(rst_n), .flush(flush),
            .x_i(stuff_i), .x_q(stuff_q),
            .y_i(out_i[k*W_IN +: W_IN]), .y_q(out_q[k*W_IN +: W_IN])
        );
    end

    // R3: tags outside the channel range must not be presented
    assert_tag_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> (int'(in_ch) < NCH));

    // R2: the frame counter wraps after RATE cycles
    assert_phase_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && int'(q.phase) == RATE - 1) |=> (q.phase == '0));

    // R2: the phase never leaves its range
    assert_phase_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        int'(q.phase) < RATE);

    // R7: clear zeroes every output on the next cycle
    assert_clear_out_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (out_i == '0 && out_q == '0));

    // R9: a frame start with no arrival leaves nothing held
    assert_hold_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (feed && !in_valid && !flush) |=> (q.hold_i == '0 && q.hold_q == '0));

endmodule

// File: tb/sim_cic_mc_interp.sv
module sim_cic_mc_interp;

    localparam int NCH   = 2;
    localparam int RATE  = 6;
    localparam int ORDER = 5;
    localparam int W_IN  = 16;
    localparam int W_ACC = 29;
    localparam int SHIFT = 11;
    localparam longint MASK = (64'sd1 <<< W_ACC) - 1;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                flush = 1'b0;
    logic                in_valid = 1'b0;
    logic [0:0]          in_ch = '0;
    logic [W_IN-1:0]     in_i = '0;
    logic [W_IN-1:0]     in_q = '0;
    logic [NCH*W_IN-1:0] out_i, out_q;

    always #2.5 clk = ~clk;

    cic_mc_interp #(.NCH(NCH), .RATE(RATE), .ORDER(ORDER), .W_IN(W_IN)) u0 (
        .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid),
        .in_ch(in_ch), .in_i(in_i), .in_q(in_q), .out_i(out_i), .out_q(out_q)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // arithmetic model, index [iq][ch][stage]
    longint m_hist [2][NCH][ORDER];
    longint m_sum  [2][NCH][ORDER];
    longint m_hold [2][NCH];
    int     m_phase;

    // frame stimulus
    bit f_v [NCH];
    int f_i [NCH];
    int f_q [NCH];

    task automatic check(input string tag, input longint got, input longint exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
        end
    endtask

    task automatic model_clear();
        for (int a = 0; a < 2; a++)
            for (int c = 0; c < NCH; c++) begin
                m_hold[a][c] = 0;
                for (int k = 0; k < ORDER; k++) begin
                    m_hist[a][c][k] = 0;
                    m_sum[a][c][k]  = 0;
                end
            end
        m_phase = 0;
    endtask

    task automatic model_step(input bit v, input int ch, input int xi, input int xq, input bit fl);
        longint x, y, t;
        if (fl) begin
            model_clear();
            return;
        end
        for (int a = 0; a < 2; a++)
            for (int c = 0; c < NCH; c++) begin
                x = (m_phase == 0) ? m_hold[a][c] : 0;
                for (int k = 0; k < ORDER; k++) begin
                    m_sum[a][c][k] = (m_sum[a][c][k] + x) & MASK;
                    x = m_sum[a][c][k];
                end
                if (m_phase == 0) m_hold[a][c] = 0;
            end
        if (v) begin
            for (int a = 0; a < 2; a++) begin
                y = longint'((a == 0) ? xi : xq) & MASK;
                for (int k = 0; k < ORDER; k++) begin
                    t = y;
                    y = (y - m_hist[a][ch][k]) & MASK;
                    m_hist[a][ch][k] = t;
                end
                m_hold[a][ch] = y;
            end
        end
        m_phase = (m_phase == RATE - 1) ? 0 : m_phase + 1;
    endtask

    task automatic compare(input string tag);
        longint e;
        for (int c = 0; c < NCH; c++) begin
            e = (m_sum[0][c][ORDER-1] >> SHIFT) & 16'hFFFF;
            check(tag, longint'(out_i[c*W_IN +: W_IN]), e);
            e = (m_sum[1][c][ORDER-1] >> SHIFT) & 16'hFFFF;
            check(tag, longint'(out_q[c*W_IN +: W_IN]), e);
        end
    endtask

    // one clock: drive at negedge, model the edge, compare at next negedge
    task automatic cyc(input bit v, input int ch, input int xi, input int xq, input bit fl,
                       input string tag);
        in_valid = v;
        in_ch    = ch[0:0];
        in_i     = xi[W_IN-1:0];
        in_q     = xq[W_IN-1:0];
        flush    = fl;
        @(posedge clk);
        model_step(v, ch, xi, xq, fl);
        @(negedge clk);
        in_valid = 1'b0;
        flush    = 1'b0;
        compare(tag);
    endtask

    // one frame of RATE cycles; channel c arrives in slot off+c
    task automatic frame(input int off, input string tag);
        for (int j = 0; j < RATE; j++) begin
            int c;
            c = j - off;
            if (c >= 0 && c < NCH && f_v[c]) cyc(1, c, f_i[c], f_q[c], 0, tag);
            else                             cyc(0, 0, 0, 0, 0, tag);
        end
    endtask

    task automatic set_all(input bit v, input int xi, input int xq);
        for (int c = 0; c < NCH; c++) begin
            f_v[c] = v; f_i[c] = xi; f_q[c] = xq;
        end
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int lfsr;
        model_clear();
        set_all(0, 0, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check("R1 out_i zero", longint'(out_i), 0);
        check("R1 out_q zero", longint'(out_q), 0);
        cyc(0, 0, 0, 0, 0, "R1 idle");

        // R2: single sample in slot 1, appears after the next phase 0
        cyc(0, 0, 0, 0, 1, "R7 clear");
        set_all(0, 0, 0);
        f_v[0] = 1; f_i[0] = 32767; f_q[0] = -32768;
        frame(1, "R2 impulse load");
        set_all(0, 0, 0);
        cyc(0, 0, 0, 0, 0, "R2 impulse feed");
        check("R2 first out i", longint'($signed(out_i[W_IN-1:0])), 15);
        check("R2 first out q", longint'($signed(out_q[W_IN-1:0])), -16);
        for (int n = 0; n < RATE * 3 - 1; n++) cyc(0, 0, 0, 0, 0, "R2 impulse tail");

        // sweep slot offsets including the phase-0 collision (R4)
        for (int off = 0; off <= RATE - NCH; off++) begin
            cyc(0, 0, 0, 0, 1, "R7 clear");
            lfsr = 32'h1234 + off;
            for (int fr = 0; fr < 12; fr++) begin
                for (int c = 0; c < NCH; c++) begin
                    lfsr = (lfsr * 1103515245 + 12345) & 32'h7fffffff;
                    f_v[c] = ((lfsr >> 3) % 5) != 0;           // R9 missing samples
                    f_i[c] = ((lfsr >> 8) & 16'hFFFF) - 32768;
                    f_q[c] = ((lfsr >> 12) & 16'hFFFF) - 32768;
                end
                frame(off, off == 0 ? "R4 phase0 arrival" : "R3 random");
            end
            // R8: alternating full scale
            for (int fr = 0; fr < 10; fr++) begin
                set_all(1, (fr % 2) ? -32768 : 32767, (fr % 2) ? 32767 : -32768);
                frame(off, "R8 full scale");
            end
        end

        // R5: only channel 0 active, channel 1 must stay zero
        cyc(0, 0, 0, 0, 1, "R7 clear");
        for (int fr = 0; fr < 6; fr++) begin
            set_all(0, 0, 0);
            f_v[0] = 1; f_i[0] = 20000 - fr * 7000; f_q[0] = fr * 3000;
            for (int j = 0; j < RATE; j++) begin
                if (j == 2) cyc(1, 0, f_i[0], f_q[0], 0, "R5 isolation");
                else        cyc(0, 0, 0, 0, 0, "R5 isolation");
                check("R5 ch1 i", longint'(out_i[W_IN +: W_IN]), 0);
                check("R5 ch1 q", longint'(out_q[W_IN +: W_IN]), 0);
            end
        end

        // R6: DC gain
        cyc(0, 0, 0, 0, 1, "R7 clear");
        set_all(1, 32767, -32768);
        for (int fr = 0; fr < 10; fr++) frame(0, "R6 step");
        for (int j = 0; j < RATE; j++) begin
            cyc(1, 0, 32767, -32768, 0, "R6 step");
            check("R6 dc i", longint'($signed(out_i[W_IN-1:0])), 20735);
            check("R6 dc q", longint'($signed(out_q[W_IN-1:0])), -20736);
        end

        // R7: clear with a sample in the same cycle leaves no trace
        cyc(1, 1, 30000, -30000, 1, "R7 clear priority");
        for (int n = 0; n < RATE * 3; n++) begin
            cyc(0, 0, 0, 0, 0, "R7 after clear");
            check("R7 i zero", longint'(out_i), 0);
            check("R7 q zero", longint'(out_q), 0);
        end
        set_all(1, 1000, -1000);
        for (int fr = 0; fr < 4; fr++) frame(1, "R7 resume");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule